// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Match Unit

This block sits beside a 32-bit processor pipeline and decides, every cycle, whether the instruction being fetched or the data access being issued has to be stopped for the debugger. Software loads it through a small CSR port. The port reaches three kinds of register: a set of instruction-breakpoint registers, a set of data-watchpoint address registers, and one shared control register. The control register holds a 2-bit mode for each watchpoint.

The compare results are combinational, taken from registered configuration. An exception request therefore appears in the same cycle as the fetch or access that caused it. The core can then squash the instruction before it executes, or drop the store or load write-back before it commits. Breakpoints are checked at fetch, which is an earlier stage than the data access, so they win when both fire in one cycle. The core handles vectoring and pipeline flush.

The interface has no streaming data path. All pins are plain control and status signals with no back-pressure. A CSR write is accepted on every cycle in which `csr_we` is high.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every register reads back zero, and `exc_req` stays low for any fetch or access, so no breakpoint or watchpoint is armed.
- R2: A CSR write stores `csr_wdata` unchanged, enable bit included. From the next cycle the combinational readback (`csr_sel`/`csr_idx`) returns it. Selector encoding: 0 = control register (index ignored), 1 = breakpoint, 2 = watchpoint, 3 = unused.
- R3: A write with selector 3, or with a breakpoint/watchpoint index of 4 or more, changes no register. Reads of such locations return zero.
- R4: Breakpoint n fires when `fetch_valid` is high, bit 0 of its register is 1, and `fetch_pc[31:2]` equals register bits 31:2. PC bits 1:0 are ignored. The request is `exc_req`=1, `exc_code`=1 and `hit_idx`=n, in the same cycle.
- R5: A breakpoint whose register has bit 0 clear never fires, even when the address matches.
- R6: Watchpoint n takes its mode from control bits [2n+3:2n+2]: 0 = off, 1 = reads, 2 = writes, 3 = both. `mem_write`=1 marks a write.
- R7: A watchpoint fires only on an exact match of all 32 address bits, with `mem_valid` high and a direction its mode allows. The result is `exc_req`=1, `exc_code`=2 and `hit_idx`=n in the same cycle as the access.
- R8: A new control value takes effect on the next cycle for every watchpoint. Rewriting a watchpoint address keeps the mode currently held in the control register.
- R9: If a breakpoint and a watchpoint fire in one cycle, the breakpoint is reported. Among several hits of one kind, the lowest index is reported.
- R10: With neither `fetch_valid` nor `mem_valid` high, `exc_req` is low, `exc_code` is 0 and `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | Register kind: 0 control, 1 breakpoint, 2 watchpoint |
| csr_idx | input | 3 | Breakpoint/watchpoint index |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Combinational readback of the selected register |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | 32 | Fetch program counter |
| mem_valid | input | 1 | Data access is valid this cycle |
| mem_addr | input | 32 | Data byte address |
| mem_write | input | 1 | 1 = store, 0 = load |
| exc_req | output | 1 | Debug exception request |
| exc_code | output | 2 | 0 none, 1 breakpoint, 2 watchpoint |
| hit_idx | output | 2 | Index of the reported unit |

## Verification
The bench builds the unit with its default parameters: four breakpoints, four watchpoints, a 32-bit datapath and a 3-bit CSR index. The 3-bit index makes indices 4 to 7 reachable from the bench, so ignored writes and zero readback can be observed. With four units of each kind, the bench reaches the top mode field (bits 9:8). It can also arm two breakpoints on one address to exercise lowest-index priority, and raise a watchpoint hit alongside a breakpoint hit to exercise the cross-kind priority.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BP   = 2'd1,
    SEL_WP   = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    WPM_OFF  = 2'd0,
    WPM_RD   = 2'd1,
    WPM_WR   = 2'd2,
    WPM_RW   = 2'd3
  } wp_mode_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_BREAK = 2'd1,
    EXC_WATCH = 2'd2
  } exc_code_e;
endpackage

// File: rtl/dbgm_csr_regs.sv
module dbgm_csr_regs
  import dbgm_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         csr_we,
  input  logic [1:0]                   csr_sel,
  input  logic [IDX_W-1:0]             csr_idx,
  input  logic [XLEN-1:0]              csr_wdata,
  output logic [XLEN-1:0]              csr_rdata,
  output logic [NUM_BP-1:0][XLEN-1:0]  bp_regs,
  output logic [NUM_WP-1:0][XLEN-1:0]  wp_regs,
  output logic [XLEN-1:0]              ctrl_reg
);
  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_reg <= '0;
    else if (csr_we && sel == SEL_CTRL)  ctrl_reg <= csr_wdata;
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bp_regs[i] <= '0;
      else if (csr_we && sel == SEL_BP && csr_idx == IDX_W'(i))
        bp_regs[i] <= csr_wdata;
    end
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wp_regs[i] <= '0;
      else if (csr_we && sel == SEL_WP && csr_idx == IDX_W'(i))
        wp_regs[i] <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (sel)
      SEL_CTRL: csr_rdata = ctrl_reg;
      SEL_BP: begin
        for (int i = 0; i < NUM_BP; i++)
          if (csr_idx == IDX_W'(i)) csr_rdata = bp_regs[i];
      end
      SEL_WP: begin
        for (int i = 0; i < NUM_WP; i++)
          if (csr_idx == IDX_W'(i)) csr_rdata = wp_regs[i];
      end
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgm_bp_match.sv
module dbgm_bp_match #(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4
) (
  input  logic [NUM_BP-1:0][XLEN-1:0] bp_regs,
  input  logic                        fetch_valid,
  input  logic [XLEN-1:0]             fetch_pc,
  output logic [NUM_BP-1:0]           hit_vec
);
  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    // bit 0 is the enable; instruction addresses are word aligned
    assign hit_vec[i] = fetch_valid && bp_regs[i][0] &&
                        (fetch_pc[XLEN-1:2] == bp_regs[i][XLEN-1:2]);
  end
endmodule

// File: rtl/dbgm_wp_match.sv
module dbgm_wp_match
  import dbgm_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_WP = 4
) (
  input  logic [NUM_WP-1:0][XLEN-1:0] wp_regs,
  input  logic [XLEN-1:0]             ctrl_reg,
  input  logic                        mem_valid,
  input  logic [XLEN-1:0]             mem_addr,
  input  logic                        mem_write,
  output logic [NUM_WP-1:0]           hit_vec
);
  for (genvar i = 0; i < NUM_WP; i++) begin : g_cmp
    wp_mode_e mode;
    logic     dir_ok;
    // mode field for unit i sits two bits above unit i-1, starting at bit 2
    assign mode   = wp_mode_e'(ctrl_reg[2*(i+1) +: 2]);
    assign dir_ok = mem_write ? (mode == WPM_WR || mode == WPM_RW)
                              : (mode == WPM_RD || mode == WPM_RW);
    assign hit_vec[i] = mem_valid && dir_ok && (mem_addr == wp_regs[i]);
  end
endmodule

// File: rtl/dbgm_prio.sv
module dbgm_prio #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = W'(i);
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbgm_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 3,
  localparam int MAXN  = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int HIT_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic [IDX_W-1:0] csr_idx,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             fetch_valid,
  input  logic [XLEN-1:0]  fetch_pc,
  input  logic             mem_valid,
  input  logic [XLEN-1:0]  mem_addr,
  input  logic             mem_write,
  output logic             exc_req,
  output logic [1:0]       exc_code,
  output logic [HIT_W-1:0] hit_idx
);
  logic [NUM_BP-1:0][XLEN-1:0] bp_regs;
  logic [NUM_WP-1:0][XLEN-1:0] wp_regs;
  logic [XLEN-1:0]             ctrl_reg;
  logic [NUM_BP-1:0]           bp_hits;
  logic [NUM_WP-1:0]           wp_hits;
  logic                        bp_any, wp_any;
  logic [HIT_W-1:0]            bp_idx, wp_idx;

  dbgm_csr_regs #(.XLEN(XLEN), .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .bp_regs(bp_regs),
    .wp_regs(wp_regs), .ctrl_reg(ctrl_reg)
  );

  dbgm_bp_match #(.XLEN(XLEN), .NUM_BP(NUM_BP)) u_bp (
    .bp_regs(bp_regs), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .hit_vec(bp_hits)
  );

  dbgm_wp_match #(.XLEN(XLEN), .NUM_WP(NUM_WP)) u_wp (
    .wp_regs(wp_regs), .ctrl_reg(ctrl_reg), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_write(mem_write), .hit_vec(wp_hits)
  );

  dbgm_prio #(.N(NUM_BP), .W(HIT_W)) u_bp_prio (.req(bp_hits), .any(bp_any), .idx(bp_idx));
  dbgm_prio #(.N(NUM_WP), .W(HIT_W)) u_wp_prio (.req(wp_hits), .any(wp_any), .idx(wp_idx));

  // fetch-stage breakpoints outrank data-stage watchpoints
  always_comb begin
    exc_req  = bp_any || wp_any;
    exc_code = EXC_NONE;
    hit_idx  = '0;
    if (bp_any) begin
      exc_code = EXC_BREAK;
      hit_idx  = bp_idx;
    end else if (wp_any) begin
      exc_code = EXC_WATCH;
      hit_idx  = wp_idx;
    end
  end
endmodule

// File: rtl/dbgm_checker.sv
module dbgm_checker #(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 3,
  parameter int HIT_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [1:0]       csr_sel,
  input logic [IDX_W-1:0] csr_idx,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             fetch_valid,
  input logic             mem_valid,
  input logic             exc_req,
  input logic [1:0]       exc_code,
  input logic [HIT_W-1:0] hit_idx
);
  logic loc_ok;
  assign loc_ok = (csr_sel == 2'd0) ||
                  (csr_sel == 2'd1 && int'(csr_idx) < NUM_BP) ||
                  (csr_sel == 2'd2 && int'(csr_idx) < NUM_WP);

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_we) && $past(loc_ok) && $stable(csr_sel) && $stable(csr_idx)
      |-> csr_rdata == $past(csr_wdata));

  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_ok |-> csr_rdata == '0);

  a_r4_break_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code == 2'd1 |-> fetch_valid && exc_req);

  a_r7_watch_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code == 2'd2 |-> mem_valid && exc_req);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid && !mem_valid |-> !exc_req && exc_code == 2'd0 && hit_idx == '0);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_code == 2'd1 || exc_code == 2'd2);
endmodule

bind dbg_match_unit dbgm_checker #(
  .XLEN(XLEN), .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .IDX_W(IDX_W), .HIT_W(HIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_valid(fetch_valid),
  .mem_valid(mem_valid), .exc_req(exc_req), .exc_code(exc_code), .hit_idx(hit_idx)
);

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [2:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_addr = '0;
  logic        mem_write = 1'b0;
  logic        exc_req;
  logic [1:0]  exc_code;
  logic [1:0]  hit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        req;
    logic [1:0]  code;
    logic [1:0]  idx;
    bit          chk_rd;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  dbg_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_write(mem_write), .exc_req(exc_req), .exc_code(exc_code), .hit_idx(hit_idx)
  );

  // monitor: compare mid-cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (exc_req !== e.req || exc_code !== e.code || hit_idx !== e.idx) begin
          errors++;
          $display("FAIL %s: req/code/idx got %0b/%0d/%0d expected %0b/%0d/%0d",
                   e.tag, exc_req, exc_code, hit_idx, e.req, e.code, e.idx);
        end
        if (e.chk_rd) begin
          checks++;
          if (csr_rdata !== e.rd) begin
            errors++;
            $display("FAIL %s: rdata got %h expected %h", e.tag, csr_rdata, e.rd);
          end
        end
      end
    end
  end

  task automatic csr_wr(input logic [1:0] s, input logic [2:0] i, input logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_sel = s; csr_idx = i; csr_wdata = d;
    fetch_valid = 1'b0; mem_valid = 1'b0;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic step(input logic [1:0] s, input logic [2:0] i,
                      input logic fv, input logic [31:0] pc,
                      input logic mv, input logic [31:0] ma, input logic mw,
                      input logic er, input logic [1:0] ec, input logic [1:0] ei,
                      input bit crd, input logic [31:0] rd, input string tag);
    exp_t e;
    @(posedge clk); #1;
    csr_we = 1'b0; csr_sel = s; csr_idx = i;
    fetch_valid = fv; fetch_pc = pc; mem_valid = mv; mem_addr = ma; mem_write = mw;
    e.req = er; e.code = ec; e.idx = ei; e.chk_rd = crd; e.rd = rd; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    step(2'd1, 3'd0, 1, 32'h0, 1, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h0, "R1 bp0 zero");
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h0, 1, 0, 2'd0, 2'd0, 1, 32'h0, "R1 ctrl zero");

    // breakpoint 0 armed at 0x1000
    csr_wr(2'd1, 3'd0, 32'h0000_1001);
    step(2'd1, 3'd0, 1, 32'h1000, 0, 32'h0, 0, 1, 2'd1, 2'd0, 1, 32'h1001, "R2 R4 bp0 hit");
    step(2'd1, 3'd0, 1, 32'h1003, 0, 32'h0, 0, 1, 2'd1, 2'd0, 0, 32'h0, "R4 low pc bits ignored");
    step(2'd1, 3'd0, 1, 32'h1004, 0, 32'h0, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R4 next word misses");
    step(2'd1, 3'd0, 0, 32'h1000, 0, 32'h0, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R10 no fetch_valid");

    // R5: disabled breakpoint
    csr_wr(2'd1, 3'd1, 32'h0000_2000);
    step(2'd1, 3'd1, 1, 32'h2000, 0, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h2000, "R5 bp1 disabled");

    // R3: out-of-range writes ignored
    csr_wr(2'd1, 3'd5, 32'hFFFF_FFFF);
    csr_wr(2'd3, 3'd0, 32'hFFFF_FFFF);
    step(2'd1, 3'd5, 0, 32'h0, 0, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h0, "R3 idx5 reads zero");
    step(2'd1, 3'd0, 0, 32'h0, 0, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h1001, "R3 bp0 untouched");
    step(2'd0, 3'd0, 0, 32'h0, 0, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h0, "R3 ctrl untouched");
    step(2'd1, 3'd1, 1, 32'h2000, 0, 32'h0, 0, 0, 2'd0, 2'd0, 1, 32'h2000, "R3 bp1 untouched");

    // watchpoint 0 at 0x4000, mode off
    csr_wr(2'd2, 3'd0, 32'h0000_4000);
    step(2'd2, 3'd0, 0, 32'h0, 1, 32'h4000, 0, 0, 2'd0, 2'd0, 1, 32'h4000, "R6 mode off");
    // mode read for wp0 at bits 3:2
    csr_wr(2'd0, 3'd0, 32'h0000_0004);
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h4000, 0, 1, 2'd2, 2'd0, 1, 32'h4, "R6 R7 wp0 read hit");
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h4000, 1, 0, 2'd0, 2'd0, 0, 32'h0, "R6 write ignored in read mode");
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h4001, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R7 exact byte only");
    step(2'd0, 3'd0, 0, 32'h0, 0, 32'h4000, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R10 no mem_valid");
    // R8: switch wp0 to write mode
    csr_wr(2'd0, 3'd0, 32'h0000_0008);
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h4000, 1, 1, 2'd2, 2'd0, 0, 32'h0, "R8 wp0 write hit");
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h4000, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R8 wp0 read now ignored");

    // wp3 both directions, bits 9:8
    csr_wr(2'd2, 3'd3, 32'h0000_5000);
    csr_wr(2'd0, 3'd0, 32'h0000_0308);
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h5000, 0, 1, 2'd2, 2'd3, 1, 32'h308, "R6 wp3 read hit");
    step(2'd0, 3'd0, 0, 32'h0, 1, 32'h5000, 1, 1, 2'd2, 2'd3, 0, 32'h0, "R6 wp3 write hit");
    // R8: new address keeps current mode
    csr_wr(2'd2, 3'd3, 32'h0000_6000);
    step(2'd2, 3'd3, 0, 32'h0, 1, 32'h6000, 1, 1, 2'd2, 2'd3, 1, 32'h6000, "R8 wp3 rearmed");
    step(2'd2, 3'd3, 0, 32'h0, 1, 32'h5000, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R8 old address dead");

    // R9: priority
    step(2'd0, 3'd0, 1, 32'h1000, 1, 32'h4000, 1, 1, 2'd1, 2'd0, 0, 32'h0, "R9 bp beats wp");
    csr_wr(2'd1, 3'd2, 32'h0000_1001);
    step(2'd0, 3'd0, 1, 32'h1000, 0, 32'h0, 0, 1, 2'd1, 2'd0, 0, 32'h0, "R9 lowest bp index");
    csr_wr(2'd1, 3'd0, 32'h0000_1000);
    step(2'd0, 3'd0, 1, 32'h1000, 1, 32'h6000, 0, 1, 2'd1, 2'd2, 0, 32'h0, "R9 bp2 after bp0 off");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule